// File: doc/BRIEF.md
# Interrupt Redirection and Message Delivery Engine

This block watches a bank of interrupt input lines and converts each pending, unmasked request into a single message-signalled interrupt write made of a 32-bit address and a 32-bit data word. Every pin has a routing entry that supplies its vector, delivery mode, destination, destination mode, trigger mode and mask. A separate register block holds these entries, and they reach this engine as per-field buses. The engine owns the per-pin pending state and the per-pin remote-pending state, and it returns the remote-pending bits so the register block can read them.

Each pin runs in edge mode or in level mode. An edge pin latches a rising input only while it is unmasked, and it forgets the event once the message goes out. A level pin mirrors its input. After a level pin is delivered it is blocked until an end-of-interrupt strobe arrives with its vector. If the input is still high at that point, the pin is delivered again. Only one message is in flight at a time. When several pins are ready, the lowest-numbered one wins.

Top module: `irq_route_engine`

## Requirements
- R1: After reset, `msg_valid` is low and every bit of `remote_pend` is 0.
- R2: Input 0 drives pin 2, together with input 2 through an OR. No input drives pin 0. Every other input k drives pin k.
- R3: A rising edge on an unmasked edge-mode pin (`ent_level` bit = 0) produces exactly one message, however long the input then stays high. A later rising edge produces one more message.
- R4: A rising edge on a masked edge-mode pin (`ent_mask` bit = 1) is dropped. Unmasking the pin afterwards produces no message.
- R5: A delivered level-mode pin (`ent_level` bit = 1) sets its `remote_pend` bit. While that bit is set, the pin produces no further message, even though its input stays high.
- R6: The pending state of a level-mode pin follows its input. A pin that was raised and then lowered while masked produces no message when it is unmasked.
- R7: An end-of-interrupt with a vector equal to the entry's vector clears the pin's `remote_pend` bit. If the input is still high, the pin is delivered once more. If the input is low, nothing is sent.
- R8: An end-of-interrupt with a vector that matches no entry leaves `remote_pend` unchanged and sends nothing.
- R9: A masked level-mode pin keeps its pending state while its input stays high. The pin is delivered when it is unmasked.
- R10: When several pins are ready at once, messages are issued in increasing pin order.
- R11: The message address is 0xFEE00000 OR (destination << 12) OR (destination mode << 2). The message data is vector[7:0] OR (delivery mode << 8) OR (trigger mode << 15), where trigger mode is 1 for level and 0 for edge.
- R12: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and both `msg_addr` and `msg_data` hold their values.
- R13: An entry in edge mode has its `remote_pend` bit at 0. Switching a remote-pending level pin to edge mode clears the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_PINS | Interrupt input levels, one bit per input |
| ent_vec | input | NUM_PINS*8 | Vector of pin p at bits 8p+7:8p |
| ent_dlv | input | NUM_PINS*3 | Delivery mode of pin p at bits 3p+2:3p |
| ent_dest | input | NUM_PINS*16 | Destination of pin p at bits 16p+15:16p |
| ent_dmode | input | NUM_PINS | Destination mode bit of pin p |
| ent_level | input | NUM_PINS | Trigger mode of pin p: 1 = level, 0 = edge |
| ent_mask | input | NUM_PINS | Mask of pin p: 1 = masked |
| eoi_valid | input | 1 | End-of-interrupt strobe, one cycle |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | Message is offered |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| remote_pend | output | NUM_PINS | Remote-pending bit of each pin |

## Verification
The assertions check the following on every cycle:
- a held message stays stable under backpressure;
- a masked edge pin never gains pending state;
- a level pin's pending state mirrors its input;
- edge entries never show remote-pending;
- a matching end-of-interrupt clears remote-pending;
- a newly offered message never skips a lower-numbered ready pin;
- no message is offered for a level pin that is already remote-pending.

Only the bench scenarios can show the following:
- the input-to-pin remapping;
- the exact address and data encoding;
- the absence of messages after ignored stimuli, such as a masked edge or an unmatched end-of-interrupt;
- redelivery after an end-of-interrupt that finds the input still high.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam int VEC_W          = 8;
   localparam int DLV_W          = 3;
   localparam int DEST_W         = 16;
   localparam int ADDR_DEST_LSB  = 12;
   localparam int ADDR_DMODE_BIT = 2;
   localparam int DATA_DLV_LSB   = 8;
   localparam int DATA_TRIG_BIT  = 15;

   typedef struct packed {
      logic [DEST_W-1:0] dest;
      logic              dmode;
      logic              lvl;
      logic [DLV_W-1:0]  dlv;
      logic [VEC_W-1:0]  vec;
   } route_t;

   function automatic logic [31:0] route_addr(logic [31:0] base, route_t r);
      return base | (32'(r.dest) << ADDR_DEST_LSB) | (32'(r.dmode) << ADDR_DMODE_BIT);
   endfunction

   function automatic logic [31:0] route_data(route_t r);
      return 32'(r.vec) | (32'(r.dlv) << DATA_DLV_LSB) | (32'(r.lvl) << DATA_TRIG_BIT);
   endfunction
endpackage

// File: rtl/irq_pin_slot.sv
module irq_pin_slot
   import irq_route_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl,
   input  logic             masked,
   input  logic             is_level,
   input  logic [VEC_W-1:0] vec,
   input  logic             eoi_valid,
   input  logic [VEC_W-1:0] eoi_vec,
   input  logic             take,
   output logic             pend,
   output logic             remote,
   output logic             elig
);
   logic prev;
   logic rise_hit;

   assign rise_hit = lvl & ~prev & ~masked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev   <= 1'b0;
         pend   <= 1'b0;
         remote <= 1'b0;
      end else begin
         prev <= lvl;
         if (is_level)      pend <= lvl;
         else if (rise_hit) pend <= 1'b1;
         else if (take)     pend <= 1'b0;

         if (!is_level)                           remote <= 1'b0;
         else if (take)                           remote <= 1'b1;
         else if (eoi_valid && (eoi_vec == vec))  remote <= 1'b0;
      end
   end

   // a level pin already remote-pending is coalesced: not eligible
   assign elig = pend & ~masked & ~(is_level & remote);

   // R4
   masked_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_level && masked && !pend) |=> !pend);
   // R6
   level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_level |=> (pend == $past(lvl)));
   // R13
   edge_remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_level |=> !remote);
   // R7
   eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_level && eoi_valid && (eoi_vec == vec) && !take) |=> !remote);
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
   parameter  int N  = 24,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/irq_msg_hold.sv
module irq_msg_hold
   import irq_route_pkg::*;
#(
   parameter int          IW   = 5,
   parameter logic [31:0] BASE = 32'hFEE0_0000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_ok,
   input  logic [IW-1:0] load_idx,
   input  route_t        load_route,
   output logic          msg_valid,
   input  logic          msg_ready,
   output logic [31:0]   msg_addr,
   output logic [31:0]   msg_data,
   output logic          acc,
   output logic [IW-1:0] held_idx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         held_idx  <= '0;
         msg_addr  <= '0;
         msg_data  <= '0;
      end else if (msg_valid && msg_ready) begin
         msg_valid <= 1'b0;
      end else if (!msg_valid && load_ok) begin
         msg_valid <= 1'b1;
         held_idx  <= load_idx;
         msg_addr  <= route_addr(BASE, load_route);
         msg_data  <= route_data(load_route);
      end
   end

   assign acc = msg_valid & msg_ready;

   // R12
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
   import irq_route_pkg::*;
#(
   parameter int          NUM_PINS  = 24,
   parameter int          REMAP_SRC = 0,
   parameter int          REMAP_DST = 2,
   parameter logic [31:0] MSG_BASE  = 32'hFEE0_0000
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PINS-1:0]        irq_in,
   input  logic [NUM_PINS*VEC_W-1:0]  ent_vec,
   input  logic [NUM_PINS*DLV_W-1:0]  ent_dlv,
   input  logic [NUM_PINS*DEST_W-1:0] ent_dest,
   input  logic [NUM_PINS-1:0]        ent_dmode,
   input  logic [NUM_PINS-1:0]        ent_level,
   input  logic [NUM_PINS-1:0]        ent_mask,
   input  logic                       eoi_valid,
   input  logic [VEC_W-1:0]           eoi_vector,
   output logic                       msg_valid,
   input  logic                       msg_ready,
   output logic [31:0]                msg_addr,
   output logic [31:0]                msg_data,
   output logic [NUM_PINS-1:0]        remote_pend
);
   localparam int IW = $clog2(NUM_PINS);

   if (NUM_PINS < 3 || NUM_PINS > 64) begin : g_bad_pins
      $error("NUM_PINS must lie in 3..64");
   end
   if (REMAP_SRC >= NUM_PINS || REMAP_DST >= NUM_PINS || REMAP_SRC == REMAP_DST) begin : g_bad_remap
      $error("remap source and target must be distinct valid pins");
   end

   logic [NUM_PINS-1:0] pin_lvl;
   logic [NUM_PINS-1:0] pend;
   logic [NUM_PINS-1:0] elig;
   logic [NUM_PINS-1:0] take;
   logic                pick_any;
   logic [IW-1:0]       pick_idx;
   logic                acc;
   logic [IW-1:0]       held_idx;
   route_t              pick_route;

   // input-to-pin routing: the remap source feeds the remap target
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_map
      if (p == REMAP_SRC) begin : g_src
         assign pin_lvl[p] = 1'b0;
      end else if (p == REMAP_DST) begin : g_dst
         assign pin_lvl[p] = irq_in[p] | irq_in[REMAP_SRC];
      end else begin : g_one
         assign pin_lvl[p] = irq_in[p];
      end
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_slot
      assign take[p] = acc && (held_idx == IW'(p));
      irq_pin_slot i_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .lvl       (pin_lvl[p]),
         .masked    (ent_mask[p]),
         .is_level  (ent_level[p]),
         .vec       (ent_vec[p*VEC_W +: VEC_W]),
         .eoi_valid (eoi_valid),
         .eoi_vec   (eoi_vector),
         .take      (take[p]),
         .pend      (pend[p]),
         .remote    (remote_pend[p]),
         .elig      (elig[p])
      );
   end

   irq_lowest_pick #(.N(NUM_PINS)) i_pick (
      .req (elig),
      .any (pick_any),
      .idx (pick_idx)
   );

   always_comb begin
      pick_route.vec   = ent_vec [int'(pick_idx)*VEC_W  +: VEC_W];
      pick_route.dlv   = ent_dlv [int'(pick_idx)*DLV_W  +: DLV_W];
      pick_route.dest  = ent_dest[int'(pick_idx)*DEST_W +: DEST_W];
      pick_route.dmode = ent_dmode[pick_idx];
      pick_route.lvl   = ent_level[pick_idx];
   end

   irq_msg_hold #(.IW(IW), .BASE(MSG_BASE)) i_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_ok    (pick_any),
      .load_idx   (pick_idx),
      .load_route (pick_route),
      .msg_valid  (msg_valid),
      .msg_ready  (msg_ready),
      .msg_addr   (msg_addr),
      .msg_data   (msg_data),
      .acc        (acc),
      .held_idx   (held_idx)
   );

   logic [NUM_PINS-1:0] below_held;
   assign below_held = NUM_PINS'((64'd1 << held_idx) - 64'd1);

   // R10
   priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_valid) |-> (($past(elig) & below_held) == '0));
   // R5
   coalesce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> !(ent_level[held_idx] && remote_pend[held_idx]));
   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!msg_valid && (remote_pend == '0)));
endmodule

// File: tb/test_irq_route_engine.sv
`timescale 1ns/1ps
module test_irq_route_engine;
   localparam int NP = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [NP-1:0]    irq_in = '0;
   logic [NP*8-1:0]  ent_vec;
   logic [NP*3-1:0]  ent_dlv;
   logic [NP*16-1:0] ent_dest;
   logic [NP-1:0]    ent_dmode, ent_level, ent_mask;
   logic             eoi_valid = 1'b0;
   logic [7:0]       eoi_vector = '0;
   logic             msg_valid, msg_ready;
   logic [31:0]      msg_addr, msg_data;
   logic [NP-1:0]    remote_pend;

   irq_route_engine #(.NUM_PINS(NP)) i_irq_route_engine (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .ent_vec(ent_vec), .ent_dlv(ent_dlv), .ent_dest(ent_dest),
      .ent_dmode(ent_dmode), .ent_level(ent_level), .ent_mask(ent_mask),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
      .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_addr(msg_addr), .msg_data(msg_data), .remote_pend(remote_pend)
   );

   logic [63:0] exp_q[$];
   string       tag_q[$];
   string       cur_req = "R1";
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 0;

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic logic [63:0] exp_msg(int p);
      logic [31:0] a, d;
      a = 32'hFEE0_0000 | (32'(ent_dest[p*16 +: 16]) << 12) | (32'(ent_dmode[p]) << 2);
      d = 32'(ent_vec[p*8 +: 8]) | (32'(ent_dlv[p*3 +: 3]) << 8) | (32'(ent_level[p]) << 15);
      return {a, d};
   endfunction

   task automatic expect_pin(int p, string req);
      exp_q.push_back(exp_msg(p));
      tag_q.push_back(req);
   endtask

   task automatic step(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic drain(string req);
      step(30);
      chk(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
      exp_q.delete();
      tag_q.delete();
   endtask

   task automatic cfg(int p, bit lvl, bit msk, logic [7:0] v, logic [2:0] dl, bit dm, logic [15:0] ds);
      ent_level[p] = lvl;
      ent_mask[p] = msk;
      ent_vec[p*8 +: 8] = v;
      ent_dlv[p*3 +: 3] = dl;
      ent_dmode[p] = dm;
      ent_dest[p*16 +: 16] = ds;
   endtask

   task automatic send_eoi(logic [7:0] v);
      eoi_vector = v;
      eoi_valid = 1'b1;
      step(1);
      eoi_valid = 1'b0;
   endtask

   // scoreboard monitor: a transfer happens at the next rising edge
   logic [63:0] mon_e;
   string       mon_t;
   always @(negedge clk) begin
      if (rst_n && msg_valid && msg_ready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, cur_req, {msg_addr, msg_data}, 64'd0);
         end else begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            chk({msg_addr, msg_data} == mon_e, mon_t, {msg_addr, msg_data}, mon_e);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      msg_ready = 1'b1;
      for (int p = 0; p < NP; p++) cfg(p, 1'b0, 1'b1, 8'(8'h30 + p), 3'd0, 1'b0, 16'(p));
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1
      chk(!msg_valid, "R1", 64'(msg_valid), 64'd0);
      chk(remote_pend == '0, "R1", 64'(remote_pend), 64'd0);

      // R3 with R11 encoding check on an edge pin
      cur_req = "R3";
      cfg(5, 1'b0, 1'b0, 8'h45, 3'd3, 1'b1, 16'hABCD);
      step(2);
      expect_pin(5, "R3 R11");
      irq_in[5] = 1'b1;
      step(6);
      irq_in[5] = 1'b0;
      drain("R3");
      expect_pin(5, "R3");
      irq_in[5] = 1'b1;
      step(2);
      irq_in[5] = 1'b0;
      drain("R3");

      // R2 remap of input 0 onto pin 2
      cur_req = "R2";
      cfg(0, 1'b0, 1'b0, 8'h30, 3'd0, 1'b0, 16'h0000);
      cfg(2, 1'b0, 1'b0, 8'h32, 3'd1, 1'b0, 16'h0202);
      step(2);
      expect_pin(2, "R2");
      irq_in[0] = 1'b1;
      step(3);
      irq_in[0] = 1'b0;
      drain("R2");

      // R4 masked edge is forgotten
      cur_req = "R4";
      cfg(7, 1'b0, 1'b1, 8'h47, 3'd0, 1'b0, 16'h0007);
      step(2);
      irq_in[7] = 1'b1;
      step(5);
      irq_in[7] = 1'b0;
      step(3);
      ent_mask[7] = 1'b0;
      drain("R4");

      // R5 level delivery and coalescing, R11 trigger bit
      cur_req = "R5";
      cfg(9, 1'b1, 1'b0, 8'h59, 3'd2, 1'b0, 16'h1234);
      step(2);
      expect_pin(9, "R5 R11");
      irq_in[9] = 1'b1;
      drain("R5");
      chk(remote_pend[9], "R5", 64'(remote_pend[9]), 64'd1);

      // R8 unmatched end-of-interrupt
      cur_req = "R8";
      send_eoi(8'h58);
      step(10);
      chk(remote_pend[9], "R8", 64'(remote_pend[9]), 64'd1);
      drain("R8");

      // R7 matched end-of-interrupt with input still high
      cur_req = "R7";
      expect_pin(9, "R7");
      send_eoi(8'h59);
      drain("R7");
      chk(remote_pend[9], "R7", 64'(remote_pend[9]), 64'd1);
      irq_in[9] = 1'b0;
      step(2);
      send_eoi(8'h59);
      step(3);
      chk(!remote_pend[9], "R7", 64'(remote_pend[9]), 64'd0);
      drain("R7");

      // R6 level pending follows input while masked
      cur_req = "R6";
      cfg(11, 1'b1, 1'b1, 8'h6B, 3'd0, 1'b0, 16'h000B);
      step(2);
      irq_in[11] = 1'b1;
      step(5);
      irq_in[11] = 1'b0;
      step(5);
      ent_mask[11] = 1'b0;
      drain("R6");

      // R9 masked level pin held, delivered on unmask
      cur_req = "R9";
      cfg(12, 1'b1, 1'b1, 8'h6C, 3'd1, 1'b1, 16'h00CC);
      step(2);
      irq_in[12] = 1'b1;
      step(10);
      chk(!msg_valid, "R9", 64'(msg_valid), 64'd0);
      expect_pin(12, "R9");
      ent_mask[12] = 1'b0;
      drain("R9");
      irq_in[12] = 1'b0;
      step(2);
      send_eoi(8'h6C);
      step(3);
      chk(!remote_pend[12], "R9", 64'(remote_pend[12]), 64'd0);

      // R10 ordering and R12 backpressure
      cur_req = "R10";
      cfg(14, 1'b0, 1'b0, 8'h4E, 3'd0, 1'b0, 16'h0E0E);
      cfg(15, 1'b0, 1'b0, 8'h4F, 3'd4, 1'b1, 16'h0F0F);
      cfg(16, 1'b0, 1'b0, 8'h50, 3'd5, 1'b0, 16'h1010);
      step(2);
      msg_ready = 1'b0;
      irq_in[16] = 1'b1;
      irq_in[15] = 1'b1;
      irq_in[14] = 1'b1;
      step(5);
      chk(msg_valid, "R12", 64'(msg_valid), 64'd1);
      chk({msg_addr, msg_data} == exp_msg(14), "R10", {msg_addr, msg_data}, exp_msg(14));
      step(4);
      chk(msg_valid, "R12", 64'(msg_valid), 64'd1);
      chk({msg_addr, msg_data} == exp_msg(14), "R12", {msg_addr, msg_data}, exp_msg(14));
      expect_pin(14, "R10");
      expect_pin(15, "R10");
      expect_pin(16, "R10");
      msg_ready = 1'b1;
      irq_in[16] = 1'b0;
      irq_in[15] = 1'b0;
      irq_in[14] = 1'b0;
      drain("R10");

      // R13 switching to edge mode clears remote-pending
      cur_req = "R13";
      cfg(18, 1'b1, 1'b0, 8'h72, 3'd0, 1'b0, 16'h0012);
      step(2);
      expect_pin(18, "R13");
      irq_in[18] = 1'b1;
      drain("R13");
      chk(remote_pend[18], "R13", 64'(remote_pend[18]), 64'd1);
      ent_mask[18] = 1'b1;
      step(2);
      ent_level[18] = 1'b0;
      step(2);
      chk(!remote_pend[18], "R13", 64'(remote_pend[18]), 64'd0);
      irq_in[18] = 1'b0;
      step(2);
      ent_level[18] = 1'b1;
      step(2);
      ent_mask[18] = 1'b0;
      drain("R13");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule